// File: doc/BRIEF.md
# Triple-Redundancy Majority Voter with Repair Request

This block sits after three identical copies of one function that run in lockstep. Each cycle it forms a bit-by-bit majority of the three data words. A single faulty copy is therefore hidden from downstream logic as it happens. It also works out which copy, if any, is the odd one out. It flags the case where no two copies agree.

Two kinds of evidence can trigger a repair. One is a disagreement among the copies that lasts long enough. The other is a per-copy integrity error flag, such as a configuration checksum failure. Either one raises a request to reload the device. The request is a simple handshake: it stays raised until it is acknowledged. Further requests are then held off until the reload is reported done. Voting carries on without change during the whole repair window, so the two healthy copies keep the output correct. The reload itself happens outside this block.

Top module: `tmr_voter_top`

## Requirements
- R1: `vote_data` is the bitwise majority of the three data inputs, and `vote_vld` is high when at least two valid inputs are high. Both appear one clock after the inputs are sampled.
- R2: When all three valids are high, `fault_id` reports which copy is odd one clock later. The codes are 0 when all agree, 1 when copy 0 differs from the other two, 2 for copy 1 and 3 for copy 2. When fewer than three valids are high, the code is 0.
- R3: When all three valids are high and every pair of words differs, `uncorr` is 1 and `fault_id` is 0 one clock later. If the request logic is idle, `reconf_req` rises in that same cycle, with no wait for the persistence count.
- R4: A single-copy disagreement raises `reconf_req` only on the `persist_cfg`-th consecutive cycle in which all three copies are valid and disagree. A cycle where all three are valid and agree resets the count. A cycle without all three valid leaves the count unchanged. A `persist_cfg` of 0 acts as 1.
- R5: Any high `cpN_err` input while idle raises `reconf_req` one clock later, whatever the valid inputs are.
- R6: Once raised, `reconf_req` stays high until `reconf_ack` is sampled high. It falls on the next clock.
- R7: After an acknowledge, no error, disagreement or uncorrectable pattern raises `reconf_req` until `reconf_done` is sampled high. The persistence count then starts again from zero.
- R8: Voting, `fault_id` and `uncorr` behave the same whatever the request state is.
- R9: While `rst` is high, all outputs are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp0_data | input | DATA_W | Copy 0 output word |
| cp1_data | input | DATA_W | Copy 1 output word |
| cp2_data | input | DATA_W | Copy 2 output word |
| cp0_vld | input | 1 | Copy 0 word valid |
| cp1_vld | input | 1 | Copy 1 word valid |
| cp2_vld | input | 1 | Copy 2 word valid |
| cp0_err | input | 1 | Copy 0 integrity error |
| cp1_err | input | 1 | Copy 1 integrity error |
| cp2_err | input | 1 | Copy 2 integrity error |
| persist_cfg | input | CNT_W | Consecutive disagreeing cycles needed before a request |
| vote_data | output | DATA_W | Majority-voted word |
| vote_vld | output | 1 | Voted word valid |
| fault_id | output | 2 | Odd-copy code |
| uncorr | output | 1 | All three copies differ |
| reconf_req | output | 1 | Reload request |
| reconf_ack | input | 1 | Request acknowledged |
| reconf_done | input | 1 | Reload finished |

## Verification
The voter is driven with three agreeing words, with each copy in turn corrupted in one bit and in many bits, and with three mutually different words. These patterns separate the majority function and the odd-copy codes from each other and from the uncorrectable case. Valid patterns with two and with one copy valid tell apart "at least two valid" from "all three valid". Runs of disagreement are cut short by an agreeing cycle, or stretched by a cycle with a copy not valid. These runs show whether the persistence count resets, holds or fires on the right cycle, including a threshold of 0. Error flags and uncorrectable words are applied between acknowledge and done to show that requests are masked while voting carries on.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    RQ_IDLE   = 2'd0,
    RQ_ASSERT = 2'd1,
    RQ_HOLD   = 2'd2
  } rq_state_e;

  localparam logic [1:0] FID_NONE = 2'd0;
  localparam logic [1:0] FID_CP0  = 2'd1;
  localparam logic [1:0] FID_CP1  = 2'd2;
  localparam logic [1:0] FID_CP2  = 2'd3;
endpackage

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] d0,
  input  logic [DATA_W-1:0] d1,
  input  logic [DATA_W-1:0] d2,
  input  logic              all_vld,
  output logic [DATA_W-1:0] maj,
  output logic              mismatch,
  output logic              uncorr,
  output logic [1:0]        fid
);
  import tmr_pkg::*;

  logic e01, e02, e12;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign maj[i] = (d0[i] & d1[i]) | (d0[i] & d2[i]) | (d1[i] & d2[i]);
  end

  always_comb begin
    e01      = (d0 == d1);
    e02      = (d0 == d2);
    e12      = (d1 == d2);
    mismatch = all_vld && !(e01 && e02);
    uncorr   = all_vld && !e01 && !e02 && !e12;
    fid      = FID_NONE;
    if (mismatch && !uncorr) begin
      if (e12)      fid = FID_CP0;
      else if (e02) fid = FID_CP1;
      else          fid = FID_CP2;
    end
  end
endmodule

// File: rtl/tmr_persist.sv
module tmr_persist #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             sample,
  input  logic             mismatch,
  input  logic [CNT_W-1:0] thr,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt, cnt_inc, thr_eff;

  always_comb begin
    thr_eff = (thr == '0) ? ONE : thr;
    cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + ONE;
    hit     = enable && sample && mismatch && (cnt_inc >= thr_eff);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) cnt <= '0;
    else if (sample) begin
      if (!mismatch || hit) cnt <= '0;
      else                  cnt <= cnt_inc;
    end
  end

  // R4: a cycle without all copies valid leaves the count unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (enable && !sample && !$past(rst)) |=> (cnt == $past(cnt) || !$past(enable)))
    else $error("a_r4_hold");
endmodule

// File: rtl/tmr_req_fsm.sv
module tmr_req_fsm (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic ack,
  input  logic done,
  output logic req,
  output logic idle
);
  import tmr_pkg::*;

  rq_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      RQ_IDLE:   if (trig) state_nx = RQ_ASSERT;
      RQ_ASSERT: if (ack)  state_nx = RQ_HOLD;
      RQ_HOLD:   if (done) state_nx = RQ_IDLE;
      default:   state_nx = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= RQ_IDLE;
    else     state <= state_nx;
  end

  assign req  = (state == RQ_ASSERT);
  assign idle = (state == RQ_IDLE);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req) else $error("a_r6_hold");
  a_r6_drop: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req) else $error("a_r6_drop");
  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    (state == RQ_HOLD && !done) |=> !req) else $error("a_r7_masked");
  a_r5_cause: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(req)) |-> $past(trig)) else $error("a_r5_cause");
endmodule

// File: rtl/tmr_voter_top.sv
module tmr_voter_top #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cp0_data,
  input  logic [DATA_W-1:0] cp1_data,
  input  logic [DATA_W-1:0] cp2_data,
  input  logic              cp0_vld,
  input  logic              cp1_vld,
  input  logic              cp2_vld,
  input  logic              cp0_err,
  input  logic              cp1_err,
  input  logic              cp2_err,
  input  logic [CNT_W-1:0]  persist_cfg,
  output logic [DATA_W-1:0] vote_data,
  output logic              vote_vld,
  output logic [1:0]        fault_id,
  output logic              uncorr,
  output logic              reconf_req,
  input  logic              reconf_ack,
  input  logic              reconf_done
);
  logic              all_vld, two_vld;
  logic [DATA_W-1:0] maj_c;
  logic              mism_c, unc_c, hit, idle, trig;
  logic [1:0]        fid_c;

  assign all_vld = cp0_vld & cp1_vld & cp2_vld;
  assign two_vld = (cp0_vld & cp1_vld) | (cp0_vld & cp2_vld) | (cp1_vld & cp2_vld);

  tmr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .d0(cp0_data), .d1(cp1_data), .d2(cp2_data), .all_vld(all_vld),
    .maj(maj_c), .mismatch(mism_c), .uncorr(unc_c), .fid(fid_c)
  );

  tmr_persist #(.CNT_W(CNT_W)) u_persist (
    .clk(clk), .rst(rst), .enable(idle), .sample(all_vld),
    .mismatch(mism_c), .thr(persist_cfg), .hit(hit)
  );

  assign trig = hit | unc_c | cp0_err | cp1_err | cp2_err;

  tmr_req_fsm u_fsm (
    .clk(clk), .rst(rst), .trig(trig), .ack(reconf_ack), .done(reconf_done),
    .req(reconf_req), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vote_data <= '0;
      vote_vld  <= 1'b0;
      fault_id  <= 2'd0;
      uncorr    <= 1'b0;
    end else begin
      vote_data <= maj_c;
      vote_vld  <= two_vld;
      fault_id  <= fid_c;
      uncorr    <= unc_c;
    end
  end

  // R2: three agreeing valid copies give that word and no odd copy
  a_r2_agree: assert property (@(posedge clk) disable iff (rst)
    (all_vld && cp0_data == cp1_data && cp1_data == cp2_data)
      |=> (vote_data == $past(cp0_data) && fault_id == 2'd0 && !uncorr))
    else $error("a_r2_agree");
  // R1: two matching valid copies always win
  a_r1_pair: assert property (@(posedge clk) disable iff (rst)
    (cp0_vld && cp1_vld && cp0_data == cp1_data) |=> (vote_vld && vote_data == $past(cp0_data)))
    else $error("a_r1_pair");
  // R3: uncorrectable never names a copy
  a_r3_code: assert property (@(posedge clk) disable iff (rst)
    uncorr |-> (fault_id == 2'd0 && vote_vld)) else $error("a_r3_code");
endmodule

// File: tb/tmr_voter_top_tb.sv
`timescale 1ns/1ps
module tmr_voter_top_tb;
  localparam int W = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] d0, d1, d2;
  logic v0, v1, v2, e0, e1, e2, ack, done;
  logic [CW-1:0] thr;
  logic [W-1:0] vote_data;
  logic vote_vld, uncorr, reconf_req;
  logic [1:0] fault_id;

  int n_tests = 0, n_fail = 0;
  int m_cnt = 0, m_st = 0;
  logic [W-1:0] x_data = '0;
  logic x_vld = 0, x_unc = 0, x_req = 0;
  logic [1:0] x_fid = 0;

  always #2.5 clk = ~clk;

  tmr_voter_top #(.DATA_W(W), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cp0_data(d0), .cp1_data(d1), .cp2_data(d2),
    .cp0_vld(v0), .cp1_vld(v1), .cp2_vld(v2), .cp0_err(e0), .cp1_err(e1), .cp2_err(e2),
    .persist_cfg(thr), .vote_data(vote_data), .vote_vld(vote_vld), .fault_id(fault_id),
    .uncorr(uncorr), .reconf_req(reconf_req), .reconf_ack(ack), .reconf_done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: advance one clock using the currently applied inputs
  task automatic model();
    int nv, ones, c, lim;
    bit allv, mism, unc, hit, trig;
    if (rst) begin
      x_data = '0; x_vld = 0; x_fid = 0; x_unc = 0; m_cnt = 0; m_st = 0;
    end else begin
      nv = int'(v0) + int'(v1) + int'(v2);
      allv = (nv == 3);
      for (int b = 0; b < W; b++) begin
        ones = int'(d0[b]) + int'(d1[b]) + int'(d2[b]);
        x_data[b] = (ones >= 2);
      end
      x_vld = (nv >= 2);
      mism = allv && !(d0 == d1 && d1 == d2);
      unc  = allv && (d0 != d1) && (d0 != d2) && (d1 != d2);
      x_unc = unc;
      x_fid = 0;
      if (mism && !unc) x_fid = (d1 == d2) ? 2'd1 : (d0 == d2) ? 2'd2 : 2'd3;
      lim = (thr == 0) ? 1 : int'(thr);
      c = (m_cnt == 255) ? 255 : m_cnt + 1;
      hit = (m_st == 0) && mism && (c >= lim);
      trig = hit || unc || e0 || e1 || e2;
      if (m_st != 0) m_cnt = 0;
      else if (allv) m_cnt = (mism && !hit) ? c : 0;
      case (m_st)
        0: if (trig) m_st = 1;
        1: if (ack)  m_st = 2;
        default: if (done) m_st = 0;
      endcase
    end
    x_req = (m_st == 1);
  endtask

  task automatic cyc(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                     input logic [2:0] v, input logic [2:0] e, input logic k, input logic dn,
                     input string tag);
    d0 = a; d1 = b; d2 = c; {v2, v1, v0} = v; {e2, e1, e0} = e; ack = k; done = dn;
    model();
    @(posedge clk); #1;
    chk(vote_data == x_data, tag, "vote_data(R1)", int'(vote_data), int'(x_data));
    chk(vote_vld == x_vld, tag, "vote_vld(R1)", int'(vote_vld), int'(x_vld));
    chk(fault_id == x_fid, tag, "fault_id(R2)", int'(fault_id), int'(x_fid));
    chk(uncorr == x_unc, tag, "uncorr(R3)", int'(uncorr), int'(x_unc));
    chk(reconf_req == x_req, tag, "reconf_req(R6)", int'(reconf_req), int'(x_req));
  endtask

  task automatic expect_req(input logic want, input string tag);
    chk(reconf_req == want, tag, "req point", int'(reconf_req), int'(want));
  endtask

  initial begin
    #(5.0 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1; thr = 8'd3;
    cyc(8'hFF, 8'h0F, 8'hF0, 3'b111, 3'b111, 0, 0, "R9");
    cyc(8'hFF, 8'h0F, 8'hF0, 3'b111, 3'b000, 0, 0, "R9");
    chk(vote_data == 0 && !reconf_req && fault_id == 0, "R9", "reset outputs", int'(vote_data), 0);
    rst = 0;
    // agreement and valid patterns
    cyc(8'hA5, 8'hA5, 8'hA5, 3'b111, 0, 0, 0, "R1");
    cyc(8'h3C, 8'h3C, 8'h00, 3'b011, 0, 0, 0, "R1");
    cyc(8'h11, 8'h22, 8'h33, 3'b100, 0, 0, 0, "R1");
    cyc(8'hC3, 8'h81, 8'h42, 3'b110, 0, 0, 0, "R1");
    // single-copy faults below threshold, each separated by agreement
    cyc(8'h5A, 8'h00, 8'h00, 3'b111, 0, 0, 0, "R2");
    cyc(8'h00, 8'h00, 8'h00, 3'b111, 0, 0, 0, "R2");
    cyc(8'h01, 8'h03, 8'h01, 3'b111, 0, 0, 0, "R2");
    cyc(8'h01, 8'h01, 8'h01, 3'b111, 0, 0, 0, "R2");
    cyc(8'h77, 8'h77, 8'h88, 3'b111, 0, 0, 0, "R2");
    cyc(8'h77, 8'h77, 8'h88, 3'b111, 0, 0, 0, "R4");
    expect_req(0, "R4");
    cyc(8'h77, 8'h77, 8'h77, 3'b111, 0, 0, 0, "R4"); // reset count
    cyc(8'h77, 8'h77, 8'h88, 3'b111, 0, 0, 0, "R4");
    cyc(8'h77, 8'h77, 8'h88, 3'b111, 0, 0, 0, "R4");
    cyc(8'h77, 8'h77, 8'h88, 3'b011, 0, 0, 0, "R4"); // hold
    expect_req(0, "R4");
    cyc(8'h77, 8'h77, 8'h88, 3'b111, 0, 0, 0, "R4"); // third -> request
    expect_req(1, "R4");
    // request held, voting continues
    cyc(8'h10, 8'h90, 8'h10, 3'b111, 0, 0, 0, "R8");
    cyc(8'h10, 8'h10, 8'h10, 3'b111, 0, 0, 0, "R6");
    expect_req(1, "R6");
    cyc(8'h10, 8'h10, 8'h10, 3'b111, 0, 1, 0, "R6");
    expect_req(0, "R6");
    // masked until done
    cyc(8'h01, 8'h02, 8'h04, 3'b111, 3'b101, 0, 0, "R7");
    cyc(8'hF0, 8'h0F, 8'h0F, 3'b111, 3'b010, 0, 0, "R7");
    expect_req(0, "R7");
    cyc(8'h0F, 8'h0F, 8'h0F, 3'b111, 0, 0, 1, "R7");
    // count starts fresh after done: two mismatches with thr 3 give no request
    cyc(8'h0F, 8'h0F, 8'h1F, 3'b111, 0, 0, 0, "R7");
    cyc(8'h0F, 8'h0F, 8'h1F, 3'b111, 0, 0, 0, "R7");
    expect_req(0, "R7");
    cyc(8'h0F, 8'h0F, 8'h0F, 3'b111, 0, 0, 0, "R7");
    // error input with no valid data
    cyc(8'h00, 8'h00, 8'h00, 3'b000, 3'b010, 0, 0, "R5");
    expect_req(1, "R5");
    cyc(8'h00, 8'h00, 8'h00, 3'b000, 0, 1, 0, "R5");
    cyc(8'h00, 8'h00, 8'h00, 3'b000, 0, 0, 1, "R5");
    // uncorrectable requests immediately despite high threshold
    thr = 8'd50;
    cyc(8'h01, 8'h02, 8'h04, 3'b111, 0, 0, 0, "R3");
    expect_req(1, "R3");
    cyc(8'h01, 8'h01, 8'h01, 3'b111, 0, 1, 0, "R3");
    cyc(8'h01, 8'h01, 8'h01, 3'b111, 0, 0, 1, "R3");
    // threshold zero acts as one
    thr = 8'd0;
    cyc(8'h44, 8'h45, 8'h44, 3'b111, 0, 0, 0, "R4");
    expect_req(1, "R4");
    cyc(8'h44, 8'h44, 8'h44, 3'b111, 0, 1, 0, "R4");
    cyc(8'h44, 8'h44, 8'h44, 3'b111, 0, 0, 1, "R4");
    cyc(8'h44, 8'h44, 8'h44, 3'b111, 0, 0, 0, "R4");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule